// File: doc/BRIEF.md
# Predicated Vector Lane Executor

This block takes a 256-bit vector of packed signed elements and applies a unary operation to each element: absolute value, negation or pass-through. A 32-bit predicate word decides which elements take part. The caller picks one of three element sizes: eight 32-bit lanes, sixteen 16-bit lanes or thirty-two 8-bit lanes. One 32-bit predicate serves all three sizes. Lane `i` reads predicate bit `i * (32 / lanes)`, so at the wider element sizes the bits in between are skipped. A lane whose predicate bit is clear passes its input element through unchanged.

A request is one cycle with `in_valid` high. The result appears in the output register one clock later, together with `out_valid`. A two-state controller drives `out_valid`:
- `ST_IDLE` means no result is being presented. `ST_EMIT` means a fresh result is on `out_data`.
- Transition `ACCEPT` goes from any state to `ST_EMIT` when `in_valid` is high.
- Transition `DRAIN` goes from any state to `ST_IDLE` when `in_valid` is low.

The lane datapath is combinational. It is built once for each element size, and a multiplexer on the mode code selects between the three copies.

Top module: `pred_lane_exec`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0 and `out_data` is all zeros.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_data` is loaded only on such cycles and otherwise keeps its value.
- R3: Lane 0 sits in the least significant bits of each vector. `in_mode` 0 selects 8 lanes of 32 bits, 1 selects 16 lanes of 16 bits, and 2 selects 32 lanes of 8 bits.
- R4: Lane `i` is enabled by predicate bit `i*4` in mode 0, bit `i*2` in mode 1 and bit `i` in mode 2. No other predicate bit affects any lane.
- R5: A disabled lane outputs its input element bit for bit, whatever the opcode.
- R6: `in_op` 0 gives the two's-complement absolute value, 1 gives the negation, and 2 or 3 give the element unchanged.
- R7: Absolute value and negation wrap modulo the lane width without saturation. The most negative element maps to itself.
- R8: `in_mode` 3 disables every lane, so the output equals the input vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_data | input | 256 | Packed input elements, lane 0 at bit 0 |
| in_mask | input | 32 | Predicate word |
| in_mode | input | 2 | Element size select |
| in_op | input | 2 | Operation select |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 256 | Registered result vector |

## Verification
If the controller state is wrong, `out_valid` shows it at once: the strobe is missing in the cycle after a request, or it appears in a cycle that has no matching request. If the output register is loaded at the wrong time, `out_data` changes during a gap in the requests; this is visible in the first idle cycle. A wrong predicate stride or lane slice changes one specific element in the next result. Directed vectors with a uniform negative fill make the failing lane easy to spot.

// File: rtl/pred_lane_pkg.sv
package pred_lane_pkg;
    typedef enum logic [1:0] {
        OP_ABS  = 2'd0,
        OP_NEG  = 2'd1,
        OP_KEEP = 2'd2,
        OP_NOP  = 2'd3
    } lane_op_e;

    typedef enum logic [1:0] {
        MODE_W32 = 2'd0,
        MODE_W16 = 2'd1,
        MODE_W8  = 2'd2,
        MODE_OFF = 2'd3
    } lane_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;
endpackage

// File: rtl/lane_op_unit.sv
module lane_op_unit
    import pred_lane_pkg::*;
#(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0] a,
    input  lane_op_e          op,
    input  logic              en,
    output logic [LANE_W-1:0] y
);
    logic [LANE_W-1:0] neg_a;
    logic [LANE_W-1:0] res;

    assign neg_a = (~a) + LANE_W'(1);

    always_comb begin
        unique case (op)
            OP_ABS:  res = a[LANE_W-1] ? neg_a : a;
            OP_NEG:  res = neg_a;
            default: res = a;
        endcase
    end

    assign y = en ? res : a;
endmodule

// File: rtl/lane_mask_decode.sv
module lane_mask_decode #(
    parameter int MASK_W = 32
) (
    input  logic [MASK_W-1:0]   mask,
    output logic [MASK_W/4-1:0] en_w32,
    output logic [MASK_W/2-1:0] en_w16,
    output logic [MASK_W-1:0]   en_w8
);
    localparam int N32 = MASK_W / 4;
    localparam int N16 = MASK_W / 2;

    for (genvar i = 0; i < N32; i++) begin : g_e32
        assign en_w32[i] = mask[i*4];
    end
    for (genvar i = 0; i < N16; i++) begin : g_e16
        assign en_w16[i] = mask[i*2];
    end
    assign en_w8 = mask;
endmodule

// File: rtl/lane_bank.sv
module lane_bank
    import pred_lane_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int LANE_W = 32,
    localparam int LANES = VEC_W / LANE_W
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [LANES-1:0] en,
    input  lane_op_e         op,
    output logic [VEC_W-1:0] res
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_op_unit #(.LANE_W(LANE_W)) u_op (
            .a  (vec[i*LANE_W +: LANE_W]),
            .op (op),
            .en (en[i]),
            .y  (res[i*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/pred_lane_exec.sv
module pred_lane_exec
    import pred_lane_pkg::*;
#(
    parameter int VEC_W  = 256,
    parameter int MASK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [VEC_W-1:0]  in_data,
    input  logic [MASK_W-1:0] in_mask,
    input  logic [1:0]        in_mode,
    input  logic [1:0]        in_op,
    output logic              out_valid,
    output logic [VEC_W-1:0]  out_data
);
    localparam int L32 = VEC_W / 32;
    localparam int L16 = VEC_W / 16;
    localparam int L8  = VEC_W / 8;

    lane_op_e    op;
    lane_mode_e  mode;
    emit_state_e state_q, state_d;

    logic [MASK_W/4-1:0] en_w32;
    logic [MASK_W/2-1:0] en_w16;
    logic [MASK_W-1:0]   en_w8;
    logic [VEC_W-1:0]    res_w32, res_w16, res_w8, res_sel;

    assign op   = lane_op_e'(in_op);
    assign mode = lane_mode_e'(in_mode);

    lane_mask_decode #(.MASK_W(MASK_W)) u_dec (
        .mask   (in_mask),
        .en_w32 (en_w32),
        .en_w16 (en_w16),
        .en_w8  (en_w8)
    );

    lane_bank #(.VEC_W(VEC_W), .LANE_W(32)) u_b32 (
        .vec(in_data), .en(en_w32[L32-1:0]), .op(op), .res(res_w32));
    lane_bank #(.VEC_W(VEC_W), .LANE_W(16)) u_b16 (
        .vec(in_data), .en(en_w16[L16-1:0]), .op(op), .res(res_w16));
    lane_bank #(.VEC_W(VEC_W), .LANE_W(8)) u_b8 (
        .vec(in_data), .en(en_w8[L8-1:0]), .op(op), .res(res_w8));

    always_comb begin
        unique case (mode)
            MODE_W32: res_sel = res_w32;
            MODE_W16: res_sel = res_w16;
            MODE_W8:  res_sel = res_w8;
            default:  res_sel = in_data;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        out_data <= '0;
        else if (in_valid) out_data <= res_sel;
    end

    assign out_valid = (state_q == ST_EMIT);
endmodule

// File: rtl/pred_lane_exec_chk.sv
module pred_lane_exec_chk #(
    parameter int VEC_W  = 256,
    parameter int MASK_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [VEC_W-1:0]  in_data,
    input logic [MASK_W-1:0] in_mask,
    input logic [1:0]        in_mode,
    input logic [1:0]        in_op,
    input logic              out_valid,
    input logic [VEC_W-1:0]  out_data
);
    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_no_spurious_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    assert_keep_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1]) |=> (out_data == $past(in_data)));
    assert_empty_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mask == '0) |=> (out_data == $past(in_data)));
    assert_mode_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 2'd3) |=> (out_data == $past(in_data)));
endmodule

bind pred_lane_exec pred_lane_exec_chk #(.VEC_W(VEC_W), .MASK_W(MASK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_mask(in_mask), .in_mode(in_mode), .in_op(in_op),
    .out_valid(out_valid), .out_data(out_data));

// File: tb/test_pred_lane_exec.sv
module test_pred_lane_exec;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] in_data = '0;
    logic [31:0]  in_mask = '0;
    logic [1:0]   in_mode = '0;
    logic [1:0]   in_op = '0;
    logic         out_valid;
    logic [255:0] out_data;
    int checks = 0;
    int errors = 0;
    logic [255:0] held;

    always #10 clk = ~clk;

    pred_lane_exec i_pred_lane_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_mask(in_mask), .in_mode(in_mode), .in_op(in_op),
        .out_valid(out_valid), .out_data(out_data));

    function automatic logic [31:0] op32(logic [31:0] e, logic [1:0] op);
        if (op == 2'd0) return e[31] ? 32'(0 - e) : e;
        if (op == 2'd1) return 32'(0 - e);
        return e;
    endfunction
    function automatic logic [15:0] op16(logic [15:0] e, logic [1:0] op);
        if (op == 2'd0) return e[15] ? 16'(0 - e) : e;
        if (op == 2'd1) return 16'(0 - e);
        return e;
    endfunction
    function automatic logic [7:0] op8(logic [7:0] e, logic [1:0] op);
        if (op == 2'd0) return e[7] ? 8'(0 - e) : e;
        if (op == 2'd1) return 8'(0 - e);
        return e;
    endfunction

    function automatic logic [255:0] ref_out(logic [255:0] d, logic [31:0] m,
                                             logic [1:0] md, logic [1:0] op);
        logic [255:0] r = d;
        if (md == 2'd0)
            for (int i = 0; i < 8; i++)
                if (m[i*4]) r[i*32 +: 32] = op32(d[i*32 +: 32], op);
        if (md == 2'd1)
            for (int i = 0; i < 16; i++)
                if (m[i*2]) r[i*16 +: 16] = op16(d[i*16 +: 16], op);
        if (md == 2'd2)
            for (int i = 0; i < 32; i++)
                if (m[i]) r[i*8 +: 8] = op8(d[i*8 +: 8], op);
        return r;
    endfunction

    task automatic check(string req, logic [255:0] act, logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [255:0] d, logic [31:0] m, logic [1:0] md,
                         logic [1:0] op, string req);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_mask = m; in_mode = md; in_op = op;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {255'd0, out_valid}, 256'd1);
        check(req, out_data, ref_out(d, m, md, op));
    endtask

    function automatic logic [255:0] rnd_vec();
        logic [255:0] v;
        for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [255:0] m2;
        logic [255:0] exp16;
        void'($urandom(32'd4242));
        #1;
        check("R1 reset valid", {255'd0, out_valid}, 256'd0);
        check("R1 reset data", out_data, 256'd0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset valid", {255'd0, out_valid}, 256'd0);
        check("R1 post-reset data", out_data, 256'd0);

        m2 = {16{16'hFFFE}};
        exp16 = m2;
        exp16[2*16 +: 16] = 16'd2; exp16[4*16 +: 16] = 16'd2;
        exp16[8*16 +: 16] = 16'd2; exp16[10*16 +: 16] = 16'd2;
        exp16[14*16 +: 16] = 16'd2;
        @(negedge clk);
        in_valid = 1'b1; in_data = m2; in_mask = 32'h10110112; in_mode = 2'd1; in_op = 2'd0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 16-lane odd bits skipped", out_data, exp16);

        issue({8{32'hFFFFFFFE}}, 32'h10110110, 2'd0, 2'd0, "R4 8-lane stride four");
        issue({8{32'hFFFFFFFE}}, 32'hEEEEEEEE, 2'd0, 2'd0, "R4 8-lane ignored bits");
        issue({32{8'hFE}}, 32'hA5A5A5A5, 2'd2, 2'd0, "R3 32-lane mapping");
        issue({32{8'h80}}, 32'hFFFFFFFF, 2'd2, 2'd0, "R7 abs min wraps 8b");
        check("R7 literal", out_data, {32{8'h80}});
        issue({16{16'h8000}}, 32'hFFFFFFFF, 2'd1, 2'd1, "R7 neg min wraps 16b");
        issue(256'h1, 32'h1, 2'd0, 2'd1, "R3 lane0 at LSB");
        check("R3 lane0 literal", out_data, {224'd0, 32'hFFFFFFFF});
        issue(rnd_vec(), 32'h0, 2'd1, 2'd0, "R5 empty mask");
        issue(rnd_vec(), 32'hFFFFFFFF, 2'd3, 2'd1, "R8 mode off");
        issue(rnd_vec(), 32'hFFFFFFFF, 2'd0, 2'd2, "R6 keep op");
        issue(rnd_vec(), 32'hFFFFFFFF, 2'd2, 2'd3, "R6 op three");

        held = out_data;
        @(negedge clk);
        in_data = ~held; in_mask = '1; in_mode = 2'd2; in_op = 2'd1;
        @(negedge clk);
        check("R2 no strobe when idle", {255'd0, out_valid}, 256'd0);
        check("R2 data held when idle", out_data, held);

        for (int n = 0; n < 400; n++) begin
            logic [255:0] d = rnd_vec();
            logic [31:0]  m = $urandom;
            logic [1:0]   md = 2'($urandom);
            logic [1:0]   op = 2'($urandom);
            if ($urandom % 4 == 0) begin
                held = out_data;
                @(negedge clk);
                in_valid = 1'b0; in_data = d; in_mask = m; in_mode = md; in_op = op;
                @(negedge clk);
                check("R2 random idle valid", {255'd0, out_valid}, 256'd0);
                check("R2 random idle hold", out_data, held);
            end else begin
                issue(d, m, md, op, "R4 R5 R6 random");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule